// File: doc/BRIEF.md
# Two-level hierarchical interrupt controller

The block merges interrupt events from a set of on-chip modules and from a bank of general-purpose I/O lines into one host interrupt pin. Every module source has an enable bit in a top-level enable register. Each I/O line has its own enable bit in a second enable register. An enabled event latches a sticky status bit. All the I/O lines share one top-level status bit, the summary bit at index `N_MOD`. Behind that summary bit sits a full per-line status register. The host reads this register to find which line fired.

Status bits are cleared by writing 1 to them. To clear an I/O interrupt completely, the host writes twice: once to the per-line status register and once to the summary bit. A control register sets three things: a global enable, the output type, and the output polarity. The output type is either a level that follows pending status or a pulse of a fixed number of cycles for each new event. Software reaches every register through a plain synchronous register port with combinational read data.

Top module: `irq_hub`

## Requirements
- R1: While reset is held and right after it is released, every register reads 0 and `irq_pin` is 1. Polarity 0 means the pin is active-low, so 1 is its inactive level.
- R2: The register offsets are: 0 module enables (`N_MOD+1` bits, bit `N_MOD` gates the I/O summary), 1 line enables, 2 control, 3 top status, 4 line status. Control bit 0 is the global enable, bit 1 selects pulse output (0 means level) and bit 2 is the polarity (1 means active-high). Enable and control registers read back what was written. Unmapped offsets read 0.
- R3: A module event sets its top status bit only when that source's enable bit is 1.
- R4: An I/O event sets its line status bit only when that line's enable bit is 1. Any such enabled event also sets top status bit `N_MOD`, but only when module-enable bit `N_MOD` is 1.
- R5: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: Top status bit `N_MOD` can be cleared while line status bits are still set, and those line bits stay set. The next enabled I/O event sets bit `N_MOD` again.
- R7: When an enabled event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: In level mode with the global enable on, the pin is active exactly while any top status bit is 1.
- R9: With the global enable off, the pin stays inactive. Enabled events are still recorded in status.
- R10: In pulse mode with the global enable on, an enabled event starts a pulse of `PULSE_CYC` cycles from the edge that captures it. Events that arrive during a pulse neither extend it nor restart it.
- R11: The polarity bit selects the active level of the pin in both output modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | N_GPIO | Register write data |
| reg_rdata | output | N_GPIO | Read data for `reg_addr`, combinational |
| mod_evt | input | N_MOD | Single-cycle event pulses from the modules |
| gpio_evt | input | N_GPIO | Single-cycle event pulses from the I/O lines |
| irq_pin | output | 1 | Host interrupt pin |

## Verification
The hardest case to reach from the ports is a second event that lands in the middle of an active pulse. The stimulus counts edges from the capturing event, injects a new event partway through, and then samples the pin one and two cycles before the original pulse would end. A restarted pulse would still be active at those points and would fail the check. The two-step clear is also exercised: the summary bit is cleared on its own, then a fresh event on a different line must set it again while the older line bit is still pending. A separate step drives an event and a clearing write onto the same bit in one cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    OFS_SRC_EN    = 3'd0,
    OFS_GPIO_EN   = 3'd1,
    OFS_CTRL      = 3'd2,
    OFS_SRC_STAT  = 3'd3,
    OFS_GPIO_STAT = 3'd4
  } reg_ofs_e;

  localparam int CTL_W        = 3;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_PULSE_BIT = 1;
  localparam int CTL_POL_BIT  = 2;

endpackage

// File: rtl/irq_hub_stat_bank.sv
// Enable register plus sticky write-one-to-clear status for W sources.
module irq_hub_stat_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] en_q,
  output logic [W-1:0] stat_q,
  output logic         hit_any
);

  logic [W-1:0] hit;
  logic [W-1:0] stat_d;

  always_comb begin
    hit    = evt & en_q;
    stat_d = stat_q;
    if (stat_we) stat_d = stat_q & ~wdata;
    // a new event wins over a clear in the same cycle
    stat_d  = stat_d | hit;
    hit_any = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/irq_hub_pin_drv.sv
// Control register and host pin shaping: level or fixed-width pulse.
module irq_hub_pin_drv
  import irq_hub_pkg::*;
#(
  parameter int PULSE_CYC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             pending,
  input  logic             trig,
  output logic [CTL_W-1:0] ctl_q,
  output logic             irq_pin
);

  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          busy;
  logic          active;

  always_comb begin
    busy  = (cnt_q != '0);
    cnt_d = cnt_q;
    if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end else if (ctl_q[CTL_EN_BIT] && ctl_q[CTL_PULSE_BIT] && trig) begin
      cnt_d = LOAD;
    end
    active  = ctl_q[CTL_EN_BIT] && (ctl_q[CTL_PULSE_BIT] ? busy : pending);
    irq_pin = ctl_q[CTL_POL_BIT] ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_MOD     = 8,
  parameter int N_GPIO    = 24,
  parameter int PULSE_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [N_GPIO-1:0] reg_wdata,
  output logic [N_GPIO-1:0] reg_rdata,
  input  logic [N_MOD-1:0]  mod_evt,
  input  logic [N_GPIO-1:0] gpio_evt,
  output logic              irq_pin
);

  localparam int N_TOP = N_MOD + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // register decode
  logic we_src_en, we_gpio_en, we_ctl, we_src_stat, we_gpio_stat;

  always_comb begin
    we_src_en    = reg_we && (reg_addr == OFS_SRC_EN);
    we_gpio_en   = reg_we && (reg_addr == OFS_GPIO_EN);
    we_ctl       = reg_we && (reg_addr == OFS_CTRL);
    we_src_stat  = reg_we && (reg_addr == OFS_SRC_STAT);
    we_gpio_stat = reg_we && (reg_addr == OFS_GPIO_STAT);
  end

  // second level: per-line enables and status
  logic [N_GPIO-1:0] gpio_en_q;
  logic [N_GPIO-1:0] gpio_stat_q;
  logic              gpio_hit_any;

  irq_hub_stat_bank #(.W(N_GPIO)) u_gpio_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_we   (we_gpio_en),
    .stat_we (we_gpio_stat),
    .wdata   (reg_wdata),
    .evt     (gpio_evt),
    .en_q    (gpio_en_q),
    .stat_q  (gpio_stat_q),
    .hit_any (gpio_hit_any)
  );

  // first level: module sources plus the I/O summary at index N_MOD
  logic [N_TOP-1:0] src_en_q;
  logic [N_TOP-1:0] src_stat_q;
  logic [N_TOP-1:0] src_evt;
  logic             src_hit_any;

  assign src_evt = {gpio_hit_any, mod_evt};

  irq_hub_stat_bank #(.W(N_TOP)) u_src_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_we   (we_src_en),
    .stat_we (we_src_stat),
    .wdata   (reg_wdata[N_TOP-1:0]),
    .evt     (src_evt),
    .en_q    (src_en_q),
    .stat_q  (src_stat_q),
    .hit_any (src_hit_any)
  );

  // output stage
  logic [CTL_W-1:0] ctl_q;
  logic             pending;

  assign pending = |src_stat_q;

  irq_hub_pin_drv #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_we    (we_ctl),
    .ctl_wdata (reg_wdata[CTL_W-1:0]),
    .pending   (pending),
    .trig      (src_hit_any),
    .ctl_q     (ctl_q),
    .irq_pin   (irq_pin)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_SRC_EN:    reg_rdata = N_GPIO'(src_en_q);
      OFS_GPIO_EN:   reg_rdata = gpio_en_q;
      OFS_CTRL:      reg_rdata = N_GPIO'(ctl_q);
      OFS_SRC_STAT:  reg_rdata = N_GPIO'(src_stat_q);
      OFS_GPIO_STAT: reg_rdata = gpio_stat_q;
      default:       reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_MOD     = 8,
  parameter int N_GPIO    = 24,
  parameter int PULSE_CYC = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MOD-1:0]  mod_evt,
  input logic [N_GPIO-1:0] gpio_evt,
  input logic [N_MOD:0]    src_en,
  input logic [N_MOD:0]    src_stat,
  input logic [N_GPIO-1:0] gpio_en,
  input logic [N_GPIO-1:0] gpio_stat,
  input logic [2:0]        ctl,
  input logic              irq_pin
);

  localparam int RW = $clog2(PULSE_CYC + 2) + 1;

  // length of the current active run on the pin in pulse mode
  logic [RW-1:0] run_q;
  logic          pulse_on;

  assign pulse_on = ctl[0] && ctl[1] && (irq_pin == ctl[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!pulse_on) begin
      run_q <= '0;
    end else if (run_q != '1) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R3, R7: an enabled module event is set in status on the next cycle,
  // whatever was written in that cycle
  p_evt_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mod_evt & src_en[N_MOD-1:0])) |=>
      ((src_stat[N_MOD-1:0] & $past(mod_evt & src_en[N_MOD-1:0]))
        == $past(mod_evt & src_en[N_MOD-1:0])));

  // R4: no line status bit rises unless its line was enabled
  p_line_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_stat & ~$past(gpio_stat) & ~$past(gpio_en)) == '0);

  // R6: an enabled line event raises the summary bit
  p_summary_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en[N_MOD] && (|(gpio_evt & gpio_en))) |=> src_stat[N_MOD]);

  // R8: level mode follows pending status
  p_level_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && !ctl[1]) |-> (irq_pin == (ctl[2] ? (|src_stat) : !(|src_stat))));

  // R9: global enable off keeps the pin at its inactive level
  p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |-> (irq_pin == !ctl[2]));

  // R10: a pulse never outlasts its programmed width
  p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(PULSE_CYC));

endmodule

bind irq_hub irq_hub_chk #(
  .N_MOD     (N_MOD),
  .N_GPIO    (N_GPIO),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mod_evt   (mod_evt),
  .gpio_evt  (gpio_evt),
  .src_en    (src_en_q),
  .src_stat  (src_stat_q),
  .gpio_en   (gpio_en_q),
  .gpio_stat (gpio_stat_q),
  .ctl       (ctl_q),
  .irq_pin   (irq_pin)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  import irq_hub_pkg::*;

  localparam int NM = 8;
  localparam int NG = 24;
  localparam int PC = 25;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [2:0]    reg_addr;
  logic [NG-1:0] reg_wdata;
  logic [NG-1:0] reg_rdata;
  logic [NM-1:0] mod_evt;
  logic [NG-1:0] gpio_evt;
  logic          irq_pin;

  irq_hub #(.N_MOD(NM), .N_GPIO(NG), .PULSE_CYC(PC)) u_irq_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mod_evt   (mod_evt),
    .gpio_evt  (gpio_evt),
    .irq_pin   (irq_pin)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: compares queued expectations before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_rd ? {8'h00, reg_rdata} : {31'h0, irq_pin};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NG-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic evt(input logic [NM-1:0] m, input logic [NG-1:0] g);
    mod_evt = m; gpio_evt = g;
    cyc();
    mod_evt = '0; gpio_evt = '0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    item_t it;
    reg_addr = a;
    it.is_rd = 1'b1; it.exp = e; it.tag = t;
    q.push_back(it);
    cyc();
  endtask

  task automatic exp_pin(input logic e, input string t);
    item_t it;
    it.is_rd = 1'b0; it.exp = {31'h0, e}; it.tag = t;
    q.push_back(it);
    cyc();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    mod_evt = '0; gpio_evt = '0;
    cyc(3);
    exp_pin(1'b1, "R1 pin inactive in reset");
    exp_rd(OFS_SRC_STAT, 32'h0, "R1 top status in reset");
    rst_n = 1'b1;
    cyc(3);
    exp_rd(OFS_CTRL, 32'h0, "R1 control after reset");
    exp_rd(OFS_GPIO_EN, 32'h0, "R1 line enables after reset");
    exp_pin(1'b1, "R1 pin inactive after reset");

    // R3: disabled source ignored
    evt(8'h01, '0);
    exp_rd(OFS_SRC_STAT, 32'h0, "R3 disabled module event");

    // R2: programming and readback
    wr(OFS_SRC_EN, 24'h0001FF);
    wr(OFS_GPIO_EN, 24'hFFFF0F);
    wr(OFS_CTRL, 24'h000005);
    exp_rd(OFS_SRC_EN, 32'h1FF, "R2 module enable readback");
    exp_rd(OFS_GPIO_EN, 32'hFFFF0F, "R2 line enable readback");
    exp_rd(OFS_CTRL, 32'h5, "R2 control readback");
    exp_rd(3'd7, 32'h0, "R2 unmapped offset");
    exp_pin(1'b0, "R8 idle level active-high");

    // R3/R8
    evt(8'h08, '0);
    exp_rd(OFS_SRC_STAT, 32'h8, "R3 enabled module event");
    exp_pin(1'b1, "R8 level pending");

    // R4: disabled line 4
    evt('0, 24'h000010);
    exp_rd(OFS_GPIO_STAT, 32'h0, "R4 disabled line");
    exp_rd(OFS_SRC_STAT, 32'h8, "R4 no summary from disabled line");

    // R5
    wr(OFS_SRC_STAT, 24'h0);
    exp_rd(OFS_SRC_STAT, 32'h8, "R5 write zero keeps bit");
    wr(OFS_SRC_STAT, 24'h8);
    exp_rd(OFS_SRC_STAT, 32'h0, "R5 write one clears bit");
    exp_pin(1'b0, "R8 level released");

    // R4/R6: two-level clear
    evt('0, 24'h100000);
    exp_rd(OFS_GPIO_STAT, 32'h100000, "R4 enabled line status");
    exp_rd(OFS_SRC_STAT, 32'h100, "R4 summary bit set");
    exp_pin(1'b1, "R8 pin from summary");
    wr(OFS_SRC_STAT, 24'h100);
    exp_rd(OFS_SRC_STAT, 32'h0, "R6 summary cleared alone");
    exp_rd(OFS_GPIO_STAT, 32'h100000, "R6 line status kept");
    exp_pin(1'b0, "R6 pin after summary clear");
    evt('0, 24'h000001);
    exp_rd(OFS_SRC_STAT, 32'h100, "R6 summary re-set");
    exp_rd(OFS_GPIO_STAT, 32'h100001, "R6 both lines pending");
    wr(OFS_GPIO_STAT, 24'h100001);
    wr(OFS_SRC_STAT, 24'h100);
    exp_rd(OFS_GPIO_STAT, 32'h0, "R5 line status cleared");
    exp_rd(OFS_SRC_STAT, 32'h0, "R5 top status cleared");

    // R7: set and clear in one cycle
    evt(8'h20, '0);
    mod_evt = 8'h20; reg_we = 1'b1; reg_addr = OFS_SRC_STAT; reg_wdata = 24'h20;
    cyc();
    mod_evt = '0; reg_we = 1'b0; reg_wdata = '0;
    exp_rd(OFS_SRC_STAT, 32'h20, "R7 event beats clear");

    // R9
    wr(OFS_CTRL, 24'h4);
    exp_pin(1'b0, "R9 disabled pin inactive");
    evt(8'h40, '0);
    exp_rd(OFS_SRC_STAT, 32'h60, "R9 status still recorded");
    exp_pin(1'b0, "R9 still inactive");
    wr(OFS_CTRL, 24'h5);
    exp_pin(1'b1, "R9 re-enable shows pending");
    wr(OFS_SRC_STAT, 24'h60);

    // R11: active-low level
    wr(OFS_CTRL, 24'h1);
    exp_pin(1'b1, "R11 idle high when active-low");
    evt(8'h02, '0);
    exp_pin(1'b0, "R11 active-low assert");
    wr(OFS_SRC_STAT, 24'h2);
    exp_pin(1'b1, "R11 active-low release");

    // R10: pulse, not extended by a second event
    wr(OFS_CTRL, 24'h7);
    exp_pin(1'b0, "R10 pulse mode idle");
    evt(8'h01, '0);                       // counter 25
    exp_pin(1'b1, "R10 pulse start");     // -> 24
    cyc(8);                               // -> 16
    evt(8'h02, '0);                       // -> 15
    exp_pin(1'b1, "R10 pulse mid");       // -> 14
    cyc(12);                              // -> 2
    exp_pin(1'b1, "R10 pulse two left");  // -> 1
    exp_pin(1'b1, "R10 pulse last cycle");// -> 0
    exp_pin(1'b0, "R10 pulse not extended");
    exp_rd(OFS_SRC_STAT, 32'h3, "R10 status kept in pulse mode");
    evt(8'h04, '0);                       // 25
    exp_pin(1'b1, "R10 new pulse");       // 24
    cyc(23);                              // 1
    exp_pin(1'b1, "R10 new pulse end");   // 0
    exp_pin(1'b0, "R10 new pulse over");

    // R11 in pulse mode: active-low
    wr(OFS_CTRL, 24'h3);
    exp_pin(1'b1, "R11 pulse idle high");
    evt(8'h08, '0);
    exp_pin(1'b0, "R11 active-low pulse");

    cyc(2);
    done = 1;
    summary();
    $finish;
  end

endmodule